// File: doc/BRIEF.md
# Write-Protect Gate for a Serial Memory Array

This block decides, at the moment a serial-memory controller is about to commit a write, whether that write may go ahead. Two kinds of commit are judged. An array commit writes data bytes into the memory. A status commit rewrites the non-volatile protection bits. The controller supplies:

- the write-enable latch and the write-busy flag;
- the sticky status-lock bit and the two-bit block-protect code;
- the external active-low protect pin;
- the target address.

The block answers with a one-cycle grant for the chosen commit kind. It also shows whether the pin-driven hardware lock is engaged.

The protect code guards a region aligned to the top of a 2048-byte array: nothing, the top quarter, the top half or everything. The hardware lock is the status-lock bit combined with a low protect pin. It freezes only the status bits and leaves array protection to the code. The pin is asynchronous and passes through a synchronizer first. The target address is captured when the data phase starts. One decision then covers a whole multi-byte page commit.

Top module: `wr_guard`

## Requirements
- R1: With protect code 2'b00 no address is protected. An array commit is granted at any address when the enable latch is 1 and busy is 0.
- R2: With protect code 2'b01, addresses 0x600 to 0x7FF are refused. Addresses up to 0x5FF are granted.
- R3: With protect code 2'b10, addresses 0x400 to 0x7FF are refused. Addresses up to 0x3FF are granted.
- R4: With protect code 2'b11, every address is refused for array commits.
- R5: An array commit is refused when the enable latch is 0 or when busy is 1, whatever the address.
- R6: `hw_mode` is 1 exactly when the status-lock bit is 1 and the synchronized pin is low. A status commit is refused while `hw_mode` is 1, even with the enable latch at 1.
- R7: When the pin is high or the status-lock bit is 0, a status commit is granted whenever the enable latch is 1. It is refused when the latch is 0.
- R8: `hw_mode` has no effect on array commits. An unprotected address is still granted while it is 1.
- R9: A change on `wp_n` reaches `hw_mode` after exactly two rising clock edges. A rising pin releases the lock with no other action. The synchronizer resets to the low (locking) value.
- R10: Array protection is judged on the address held by the last `cap_en`. Later changes on `cap_addr` without `cap_en` are ignored. When `cap_en` and `commit` fall in the same cycle, the newly presented address is used.
- R11: Grants appear one cycle after `commit` and last one cycle. Only the grant of the kind chosen by `commit_status` (1 = status, 0 = array) can be 1. Both grants are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Asynchronous active-low protect pin |
| srwd | input | 1 | Sticky status-lock bit |
| bp | input | 2 | Block-protect code |
| wel | input | 1 | Write-enable latch |
| wip | input | 1 | Write already in progress |
| cap_en | input | 1 | Capture the target address (start of data phase) |
| cap_addr | input | ADDR_W | Target address to capture |
| commit | input | 1 | Commit strobe for the pending write |
| commit_status | input | 1 | 1 = status commit, 0 = array commit |
| array_grant | output | 1 | Array commit allowed (one-cycle pulse) |
| status_grant | output | 1 | Status commit allowed (one-cycle pulse) |
| hw_mode | output | 1 | Hardware lock engaged |

## Verification
Two functions can land on the same edge.

The first pair is address capture and commit. The bench raises `cap_en` and `commit` together after a protected address was held earlier. It expects the fresh unprotected address to decide the grant. It then changes `cap_addr` without `cap_en` to show the held address still rules.

The second pair is a status commit and a pin edge that is still inside the synchronizer. The bench commits one edge after lowering the pin and expects a grant, because the lock is not yet visible. It commits again once `hw_mode` has risen and expects a refusal.

// File: rtl/wr_guard.sv
`timescale 1ns/1ps
module wr_guard #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              srwd,
  input  logic [1:0]        bp,
  input  logic              wel,
  input  logic              wip,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              commit,
  input  logic              commit_status,
  output logic              array_grant,
  output logic              status_grant,
  output logic              hw_mode
);
  localparam int TOP = ADDR_W - 1;

  logic [SYNC_STAGES-1:0] wp_pipe;
  logic [ADDR_W-1:0]      held_addr;
  logic [ADDR_W-1:0]      eff_addr;
  logic                   in_guard;

  always_ff @(posedge clk) begin
    if (!rst_n) wp_pipe <= '0;
    else        wp_pipe <= {wp_pipe[SYNC_STAGES-2:0], wp_n};
  end

  assign hw_mode = srwd & ~wp_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)      held_addr <= '0;
    else if (cap_en) held_addr <= cap_addr;
  end

  assign eff_addr = cap_en ? cap_addr : held_addr;

  always_comb begin
    case (bp)
      2'b00:   in_guard = 1'b0;
      2'b01:   in_guard = &eff_addr[TOP -: 2];
      2'b10:   in_guard = eff_addr[TOP];
      default: in_guard = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      array_grant  <= 1'b0;
      status_grant <= 1'b0;
    end else begin
      array_grant  <= commit & ~commit_status & wel & ~wip & ~in_guard;
      status_grant <= commit &  commit_status & wel & ~hw_mode;
    end
  end
endmodule

// File: rtl/wr_guard_chk.sv
`timescale 1ns/1ps
module wr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic [1:0] bp,
  input logic       wel,
  input logic       wip,
  input logic       commit,
  input logic       commit_status,
  input logic       array_grant,
  input logic       status_grant,
  input logic       hw_mode
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  AST_ARRAY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !commit_status && !wel) |=> !array_grant); // R5
  AST_ARRAY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !commit_status && wip) |=> !array_grant); // R5
  AST_FULL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !commit_status && bp == 2'b11) |=> !array_grant); // R4
  AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_status && hw_mode) |=> !status_grant); // R6
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (!array_grant && !status_grant)); // R11
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({array_grant, status_grant}) <= 1); // R11
  AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2 && $past(wp_n, 2)) |-> !hw_mode); // R9
endmodule

bind wr_guard wr_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .bp(bp), .wel(wel), .wip(wip),
  .commit(commit), .commit_status(commit_status),
  .array_grant(array_grant), .status_grant(status_grant), .hw_mode(hw_mode)
);

// File: tb/wr_guard_test.sv
`timescale 1ns/1ps
module wr_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, srwd = 1'b0, wel = 1'b0, wip = 1'b0;
  logic [1:0] bp = 2'b00;
  logic cap_en = 1'b0, commit = 1'b0, commit_status = 1'b0;
  logic [10:0] cap_addr = '0;
  logic array_grant, status_grant, hw_mode;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wr_guard uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .srwd(srwd), .bp(bp), .wel(wel),
    .wip(wip), .cap_en(cap_en), .cap_addr(cap_addr), .commit(commit),
    .commit_status(commit_status), .array_grant(array_grant),
    .status_grant(status_grant), .hw_mode(hw_mode)
  );

  // {bp, addr, wel, wip, expected array grant}
  localparam logic [15:0] VEC [12] = '{
    {2'b00, 11'h7FF, 1'b1, 1'b0, 1'b1},  // R1
    {2'b00, 11'h000, 1'b1, 1'b0, 1'b1},  // R1
    {2'b01, 11'h5FF, 1'b1, 1'b0, 1'b1},  // R2
    {2'b01, 11'h600, 1'b1, 1'b0, 1'b0},  // R2
    {2'b01, 11'h7FF, 1'b1, 1'b0, 1'b0},  // R2
    {2'b10, 11'h3FF, 1'b1, 1'b0, 1'b1},  // R3
    {2'b10, 11'h400, 1'b1, 1'b0, 1'b0},  // R3
    {2'b11, 11'h000, 1'b1, 1'b0, 1'b0},  // R4
    {2'b11, 11'h3FF, 1'b1, 1'b0, 1'b0},  // R4
    {2'b00, 11'h123, 1'b0, 1'b0, 1'b0},  // R5
    {2'b00, 11'h123, 1'b1, 1'b1, 1'b0},  // R5
    {2'b01, 11'h100, 1'b0, 1'b1, 1'b0}   // R5
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive a commit (optionally capturing in the same cycle), sample the grant
  task automatic do_commit(input logic is_status, input logic cap,
                           input logic [10:0] addr);
    @(negedge clk);
    cap_en = cap; cap_addr = addr; commit = 1'b1; commit_status = is_status;
    @(negedge clk);
    cap_en = 1'b0; commit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 reset array_grant", array_grant, 1'b0);
    check("R11 reset status_grant", status_grant, 1'b0);
    check("R9 reset hw_mode", hw_mode, 1'b0);

    for (int i = 0; i < 12; i++) begin
      bp = VEC[i][15:14]; wel = VEC[i][2]; wip = VEC[i][1];
      do_commit(1'b0, 1'b1, VEC[i][13:3]);
      check($sformatf("R1-R5 vector %0d", i), array_grant, VEC[i][0]);
      check("R11 no status on array commit", status_grant, 1'b0);
    end
    wip = 1'b0;

    // R11: grant lasts one cycle
    bp = 2'b00; wel = 1'b1;
    do_commit(1'b0, 1'b1, 11'h010);
    check("R11 grant pulse", array_grant, 1'b1);
    @(negedge clk);
    check("R11 grant drops", array_grant, 1'b0);

    // R10: held address rules, later cap_addr ignored
    bp = 2'b01;
    @(negedge clk); cap_en = 1'b1; cap_addr = 11'h100;
    do_commit(1'b0, 1'b0, 11'h700);
    check("R10 held low address", array_grant, 1'b1);
    @(negedge clk); cap_en = 1'b1; cap_addr = 11'h700;
    do_commit(1'b0, 1'b0, 11'h100);
    check("R10 held high address", array_grant, 1'b0);
    do_commit(1'b0, 1'b1, 11'h100);
    check("R10 same-cycle capture", array_grant, 1'b1);

    // R7: status writable with pin high / lock bit clear
    srwd = 1'b1; wp_n = 1'b1; wel = 1'b1;
    do_commit(1'b1, 1'b0, 11'h000);
    check("R7 status with pin high", status_grant, 1'b1);
    check("R11 no array on status commit", array_grant, 1'b0);
    wel = 1'b0;
    do_commit(1'b1, 1'b0, 11'h000);
    check("R7 status needs latch", status_grant, 1'b0);
    wel = 1'b1;

    // R9 + R6: pin falls; commit inside sync window still granted
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk);
    check("R9 one edge after fall", hw_mode, 1'b0);
    commit = 1'b1; commit_status = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    check("R6 commit before lock visible", status_grant, 1'b1);
    check("R9 two edges after fall", hw_mode, 1'b1);
    do_commit(1'b1, 1'b0, 11'h000);
    check("R6 status refused in lock", status_grant, 1'b0);

    // R8: lock leaves array protection alone
    bp = 2'b01;
    do_commit(1'b0, 1'b1, 11'h200);
    check("R8 array granted in lock", array_grant, 1'b1);
    do_commit(1'b0, 1'b1, 11'h650);
    check("R8 guard kept in lock", array_grant, 1'b0);

    // R7: lock bit clear with pin low
    srwd = 1'b0;
    @(negedge clk);
    check("R6 lock needs srwd", hw_mode, 1'b0);
    do_commit(1'b1, 1'b0, 11'h000);
    check("R7 status with srwd clear", status_grant, 1'b1);

    // R9: release by pin alone
    srwd = 1'b1;
    @(negedge clk);
    check("R6 lock re-engaged", hw_mode, 1'b1);
    wp_n = 1'b1;
    @(negedge clk);
    check("R9 one edge after rise", hw_mode, 1'b1);
    @(negedge clk);
    check("R9 released after rise", hw_mode, 1'b0);
    do_commit(1'b1, 1'b0, 11'h000);
    check("R7 status after release", status_grant, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule